// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog

This peripheral guards a system against software that stops making progress. Software reaches it through a small 32-bit register port with address, write strobe, write data, read strobe and read data. A free-running timebase counter can be read at any time, which lets software confirm that the clock is alive: two reads a cycle apart differ.

The watchdog itself runs only while two enable bits are both set, and they sit in two different registers. Once running, an interval counter of 2^N cycles is active. When the first interval runs out, an expiry flag is set and a level interrupt is raised. If a second interval runs out while that flag is still set, the block emits a one-cycle system reset pulse. It then records that a watchdog reset took place, and returns to the disabled state. Software keeps the system alive by writing a one to either status flag. This clears the flag and starts the interval again.

A build-time option locks the enable bits once the watchdog is running, so software cannot switch it off afterwards.

Top module: `twostage_wdog`

## Requirements
- R1: After power-on reset (`rst` high at a clock edge), every register reads zero and both `irq` and `sys_rst` are low.
- R2: Register layout. Offset 0x0 holds the status/control word: bit 3 is the reset-seen flag, bit 2 is the expiry flag and bit 1 is enable A. Offset 0x4 holds enable B in bit 0. Offset 0x8 is the read-only timebase. Unused bits and unmapped offsets read as zero. `rdata` is zero while `re` is low.
- R3: The timebase increments by one on every clock edge, so reads one cycle apart differ by one. Writes to offset 0x8 have no effect on it.
- R4: The interval counter advances only while enable A and enable B are both set. With only one of them set, no expiry ever happens.
- R5: Let E be the clock edge at which the watchdog starts running or is restarted. The first expiry sets the expiry flag and drives `irq` high at edge E+2^N, and not earlier. `irq` stays high for as long as the flag is set.
- R6: If another 2^N edges pass with the expiry flag still set, `sys_rst` is high for exactly one cycle. At that same edge the reset-seen flag is set, and the expiry flag, enable A and enable B are all cleared.
- R7: Writing offset 0x0 with bit 3 or bit 2 set clears the selected flag(s) and restarts the interval from zero. Such a write also restarts the interval when only bit 3 is set. Writing zeros to those bits clears no flag and does not restart the interval.
- R8: Clearing either enable bit stops the interval and resets it to zero. After re-enabling, the next expiry again takes a full 2^N edges. The expiry flag is kept while the watchdog is stopped.
- R9: With ENABLE_ONCE=1, writes cannot clear either enable bit while both are set. A watchdog reset still clears both.
- R10: The reset-seen flag is cleared only by writing a one to bit 3 of offset 0x0, or by power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_re | input | 1 | Read strobe; read data is combinational |
| bus_rdata | output | DATA_W | Read data, zero when not reading |
| irq | output | 1 | Level interrupt, high while the expiry flag is set |
| sys_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
A miscounted interval counter moves the rising edge of `irq` or the `sys_rst` pulse off the expected cycle, so the bench samples one cycle before and one cycle after each expected event. A wrong expiry or reset-seen flag shows at once on `irq` and in the readback of offset 0x0. A lost restart shows up as a premature interrupt or reset within one interval. A wrong enable lock shows up as a readback that changed, or as an interrupt that never comes.

// File: rtl/twostage_wdog_pkg.sv
package twostage_wdog_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    // Register offsets (byte addresses)
    localparam logic [ADDR_W-1:0] OFS_CTL = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_ARM = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_TB  = 4'h8;

    // Bit positions in the two control words
    localparam int B_RSTF = 3;
    localparam int B_EXPF = 2;
    localparam int B_ENA  = 1;
    localparam int B_ENB  = 0;

    typedef enum logic [1:0] {
        SEL_CTL,
        SEL_ARM,
        SEL_TB,
        SEL_NONE
    } sel_e;

    typedef struct packed {
        logic rst_seen;
        logic expired;
        logic en_a;
        logic en_b;
    } wd_state_t;

    function automatic sel_e decode(input logic [ADDR_W-1:0] a);
        if (a == OFS_CTL)      return SEL_CTL;
        else if (a == OFS_ARM) return SEL_ARM;
        else if (a == OFS_TB)  return SEL_TB;
        else                   return SEL_NONE;
    endfunction

endpackage

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
    parameter int TB_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    output logic [TB_W-1:0] tb
);
    always_ff @(posedge clk) begin
        if (rst) tb <= '0;
        else     tb <= tb + 1'b1;
    end
endmodule

// File: rtl/wdog_interval.sv
module wdog_interval #(
    parameter int IVL_W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic kick,
    output logic expire
);
    localparam logic [IVL_W-1:0] LAST = '1;

    logic [IVL_W-1:0] cnt;

    // Wraps to zero on the expiring edge, so the next interval is full length
    assign expire = run & ~kick & (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || kick || !run) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import twostage_wdog_pkg::*;
#(
    parameter bit ENABLE_ONCE = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_ctl,
    input  logic      wr_arm,
    input  logic [3:0] nib,
    input  logic      expire,
    output wd_state_t st,
    output logic      running,
    output logic      kick,
    output logic      sys_rst
);
    logic lock;

    assign running = st.en_a & st.en_b;
    assign kick    = wr_ctl & (nib[B_RSTF] | nib[B_EXPF]);
    assign lock    = ENABLE_ONCE & running;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= '0;
            sys_rst <= 1'b0;
        end else begin
            sys_rst <= 1'b0;
            if (wr_ctl) begin
                if (!lock)        st.en_a     <= nib[B_ENA];
                if (nib[B_RSTF])  st.rst_seen <= 1'b0;
                if (nib[B_EXPF])  st.expired  <= 1'b0;
            end
            if (wr_arm && !lock)  st.en_b     <= nib[B_ENB];
            // Expiry is last so it overrides a same-cycle enable write
            if (expire) begin
                if (st.expired) begin
                    sys_rst     <= 1'b1;
                    st.rst_seen <= 1'b1;
                    st.expired  <= 1'b0;
                    st.en_a     <= 1'b0;
                    st.en_b     <= 1'b0;
                end else begin
                    st.expired  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
    import twostage_wdog_pkg::*;
#(
    parameter int ADDR_W      = twostage_wdog_pkg::ADDR_W,
    parameter int DATA_W      = twostage_wdog_pkg::DATA_W,
    parameter int TB_W        = 32,
    parameter int IVL_W       = 16,
    parameter bit ENABLE_ONCE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              sys_rst
);
    sel_e            sel;
    wd_state_t       st;
    logic            running;
    logic            kick;
    logic            expire;
    logic            wr_ctl;
    logic            wr_arm;
    logic [TB_W-1:0] tb_val;

    assign sel    = decode(bus_addr);
    assign wr_ctl = bus_we & (sel == SEL_CTL);
    assign wr_arm = bus_we & (sel == SEL_ARM);
    assign irq    = st.expired;

    wdog_timebase #(.TB_W(TB_W)) u_timebase (
        .clk (clk),
        .rst (rst),
        .tb  (tb_val)
    );

    wdog_interval #(.IVL_W(IVL_W)) u_interval (
        .clk    (clk),
        .rst    (rst),
        .run    (running),
        .kick   (kick),
        .expire (expire)
    );

    wdog_ctrl #(.ENABLE_ONCE(ENABLE_ONCE)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_ctl  (wr_ctl),
        .wr_arm  (wr_arm),
        .nib     (bus_wdata[3:0]),
        .expire  (expire),
        .st      (st),
        .running (running),
        .kick    (kick),
        .sys_rst (sys_rst)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            case (sel)
                SEL_CTL: begin
                    bus_rdata[B_RSTF] = st.rst_seen;
                    bus_rdata[B_EXPF] = st.expired;
                    bus_rdata[B_ENA]  = st.en_a;
                end
                SEL_ARM: bus_rdata[B_ENB] = st.en_b;
                SEL_TB:  bus_rdata = DATA_W'(tb_val);
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/twostage_wdog_chk.sv
module twostage_wdog_chk #(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter int TB_W        = 32,
    parameter bit ENABLE_ONCE = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic              sys_rst,
    input logic              running,
    input logic [TB_W-1:0]   tb_val
);
    p_tb_step_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> tb_val == TB_W'($past(tb_val) + 1'b1));

    p_irq_needs_run_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(running));

    p_pulse_one_r6: assert property (@(posedge clk) disable iff (rst)
        sys_rst |=> !sys_rst);

    p_pulse_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst) |-> $past(irq) && !irq && !running);

    p_irq_clear_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> sys_rst ||
            ($past(bus_we) && $past(bus_addr) == '0 && $past(bus_wdata[2])));

    p_lock_r9: assert property (@(posedge clk) disable iff (rst)
        (ENABLE_ONCE && $past(running) && !sys_rst) |-> running);
endmodule

bind twostage_wdog twostage_wdog_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TB_W(TB_W), .ENABLE_ONCE(ENABLE_ONCE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .sys_rst   (sys_rst),
    .running   (running),
    .tb_val    (tb_val)
);

// File: tb/twostage_wdog_bench.sv
`timescale 1ns/1ps
module twostage_wdog_bench;
    localparam int IVL_W = 4;
    localparam int IVL   = 1 << IVL_W;
    localparam int NVEC  = 14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        re = 1'b0, we_a = 1'b0, we_b = 1'b0;
    logic [31:0] rdata_a, rdata_b;
    logic        irq_a, irq_b, srst_a, srst_b;
    int          errors = 0, checks = 0;

    always #5 clk = ~clk;

    twostage_wdog #(.IVL_W(IVL_W), .ENABLE_ONCE(1'b0)) u_twostage_wdog (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we_a), .bus_wdata(wdata),
        .bus_re(re), .bus_rdata(rdata_a), .irq(irq_a), .sys_rst(srst_a));

    twostage_wdog #(.IVL_W(IVL_W), .ENABLE_ONCE(1'b1)) u_twostage_wdog_once (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we_b), .bus_wdata(wdata),
        .bus_re(re), .bus_rdata(rdata_b), .irq(irq_b), .sys_rst(srst_b));

    // {is_read, offset, write data or expected read data}
    localparam logic [36:0] VEC [NVEC] = '{
        {1'b0, 4'h0, 32'h2}, {1'b1, 4'h0, 32'h2}, {1'b1, 4'h4, 32'h0},
        {1'b0, 4'h4, 32'h1}, {1'b1, 4'h4, 32'h1}, {1'b0, 4'h0, 32'hE},
        {1'b1, 4'h0, 32'h2}, {1'b0, 4'h4, 32'h0}, {1'b1, 4'h4, 32'h0},
        {1'b0, 4'h0, 32'hFFFF_FFF1}, {1'b1, 4'h0, 32'h0},
        {1'b0, 4'h8, 32'h5}, {1'b1, 4'hC, 32'h0}, {1'b1, 4'h4, 32'h0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input bit b, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        if (b) we_b = 1'b1; else we_a = 1'b1;
        @(negedge clk);
        we_a = 1'b0; we_b = 1'b0;
    endtask

    task automatic rd(input bit b, input logic [3:0] a, output logic [31:0] d);
        addr = a; re = 1'b1;
        #1;
        d = b ? rdata_b : rdata_a;
        re = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] v, t1, t2;
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state
        chk("R1 irq", {31'b0, irq_a}, 32'h0);
        chk("R1 sys_rst", {31'b0, srst_a}, 32'h0);
        rd(0, 4'h0, v); chk("R1 ctl", v, 32'h0);
        rd(0, 4'h4, v); chk("R1 arm", v, 32'h0);

        // R2 register layout table walk (also exercises R8 stop via row 7)
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][36]) begin
                rd(0, VEC[i][35:32], v);
                chk($sformatf("R2 row %0d", i), v, VEC[i][31:0]);
            end else begin
                wr(0, VEC[i][35:32], VEC[i][31:0]);
            end
        end
        addr = 4'h0; #1; chk("R2 re low", rdata_a, 32'h0);

        // R3 timebase
        rd(0, 4'h8, t1); step(1); rd(0, 4'h8, t2);
        chk("R3 step", t2 - t1, 32'h1);
        rd(0, 4'h8, t1); wr(0, 4'h8, 32'h0); rd(0, 4'h8, t2);
        chk("R3 write ignored", t2 - t1, 32'h2);

        // R4 only one enable: no expiry
        wr(0, 4'h0, 32'h2); step(40);
        chk("R4 irq", {31'b0, irq_a}, 32'h0);
        // R5 first expiry timing
        wr(0, 4'h4, 32'h1); step(IVL - 1);
        chk("R5 early", {31'b0, irq_a}, 32'h0);
        step(1);
        chk("R5 irq", {31'b0, irq_a}, 32'h1);
        rd(0, 4'h0, v); chk("R5 ctl", v, 32'h6);
        // R7 zero write keeps flag and count; R6 reset at 2*IVL
        wr(0, 4'h0, 32'h2);
        rd(0, 4'h0, v); chk("R7 zero write", v, 32'h6);
        step(IVL - 3);
        chk("R6 early", {31'b0, srst_a}, 32'h0);
        step(1);
        chk("R6 pulse", {31'b0, srst_a}, 32'h1);
        rd(0, 4'h0, v); chk("R6 ctl", v, 32'h8);
        rd(0, 4'h4, v); chk("R6 arm", v, 32'h0);
        chk("R6 irq", {31'b0, irq_a}, 32'h0);
        step(1);
        chk("R6 width", {31'b0, srst_a}, 32'h0);
        step(40);
        chk("R6 disabled", {31'b0, irq_a | srst_a}, 32'h0);
        rd(0, 4'h0, v); chk("R10 persists", v, 32'h8);
        wr(0, 4'h0, 32'h8);
        rd(0, 4'h0, v); chk("R10 w1c", v, 32'h0);

        // R7 keepalive restarts
        wr(0, 4'h0, 32'h2); wr(0, 4'h4, 32'h1); step(10);
        wr(0, 4'h0, 32'h6); step(IVL - 1);
        chk("R7 kick delays", {31'b0, irq_a}, 32'h0);
        step(1);
        chk("R7 irq after kick", {31'b0, irq_a}, 32'h1);
        wr(0, 4'h0, 32'h6);
        chk("R7 irq cleared", {31'b0, irq_a}, 32'h0);
        rd(0, 4'h0, v); chk("R7 ctl", v, 32'h2);
        step(IVL - 1);
        chk("R7 second early", {31'b0, irq_a}, 32'h0);
        step(1);
        chk("R7 second irq", {31'b0, irq_a}, 32'h1);
        wr(0, 4'h0, 32'hA);
        rd(0, 4'h0, v); chk("R7 bit3 keeps flag", v, 32'h6);
        step(IVL - 1);
        chk("R7 bit3 restarts", {31'b0, srst_a}, 32'h0);
        step(1);
        chk("R7 reset after bit3", {31'b0, srst_a}, 32'h1);
        step(2);
        // R10 power-on reset clears reset-seen
        rst = 1'b1; step(2); rst = 1'b0; step(1);
        rd(0, 4'h0, v); chk("R10 por", v, 32'h0);

        // R8 stop clears the interval
        wr(0, 4'h0, 32'h2); wr(0, 4'h4, 32'h1); step(10);
        wr(0, 4'h4, 32'h0); step(30);
        chk("R8 stopped", {31'b0, irq_a}, 32'h0);
        wr(0, 4'h4, 32'h1); step(IVL - 1);
        chk("R8 full interval", {31'b0, irq_a}, 32'h0);
        step(1);
        chk("R8 irq", {31'b0, irq_a}, 32'h1);
        wr(0, 4'h0, 32'h0); wr(0, 4'h4, 32'h0);
        chk("R8 flag kept", {31'b0, irq_a}, 32'h1);
        wr(0, 4'h0, 32'h4);
        chk("R8 flag cleared", {31'b0, irq_a}, 32'h0);

        // R9 enable-once instance
        wr(1, 4'h0, 32'h2); wr(1, 4'h4, 32'h1);
        wr(1, 4'h4, 32'h0); wr(1, 4'h0, 32'h0);
        rd(1, 4'h4, v); chk("R9 arm locked", v, 32'h1);
        rd(1, 4'h0, v); chk("R9 ctl locked", v, 32'h2);
        step(2 * IVL - 5);
        chk("R9 early", {31'b0, srst_b}, 32'h0);
        step(1);
        chk("R9 pulse", {31'b0, srst_b}, 32'h1);
        rd(1, 4'h4, v); chk("R9 reset disables", v, 32'h0);

        finish_run();
    end
endmodule